// File: doc/BRIEF.md
# Configuration Image Selection Controller

This controller decides which configuration image a programmable device loads, and when that choice falls back to the factory image. After a power-on reset or an external reconfigure request, it always starts on the factory image. From a running user mode, a user request makes it fetch a start pointer from a flash model. That pointer selects one of three things: the factory image, a fixed redirect slot, or an application image at the address given.

Flash reads and image loads are modelled as simple level-request / pulse-response handshakes. Loading an application is retried a bounded number of times before the controller gives up and returns to the factory image. A watchdog expiry in application mode also returns it to the factory image. The reason for the latest fallback stays visible on a status output until the next power-on reset.

Top module: `rcfg_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `load_req`=1, `image_addr`=0, `app_mode`=0, `user_mode`=0, `ptr_req`=0 and `fallback_cause`=2'b00 (none).
- R2: During a factory load, `load_done` without `load_err` enters factory user mode on the next edge (`user_mode`=1, `app_mode`=0). A `load_err` during a factory load keeps the factory load going.
- R3: In either user mode, `user_reconfig` raises `ptr_req` on the next edge. If the pointer returned with `ptr_valid` is 0, a factory load starts (`load_req`=1, `app_mode`=0, `image_addr`=0).
- R4: A returned pointer equal to the redirect value 32 starts an application load from the fixed slot 0x0100_0000, not from address 32.
- R5: Any other nonzero pointer starts an application load at exactly that address (`app_mode`=1, `load_req`=1, `image_addr`=pointer).
- R6: During an application load, `load_done` without `load_err` enters application user mode with `image_addr` unchanged. When both arrive in the same cycle, the error wins.
- R7: The first three load errors of an application attempt each retry the same address. The fourth error starts a factory load and sets `fallback_cause`=2'b01.
- R8: The error count restarts at zero for each new application attempt and whenever an application reaches user mode.
- R9: `wdog_timeout` in application user mode starts a factory load on the next edge and sets `fallback_cause`=2'b10.
- R10: `wdog_timeout` is ignored outside application user mode. `user_reconfig` is ignored while a load or a pointer read is in progress.
- R11: `ext_reconfig` in any state starts a factory load on the next edge and sets `fallback_cause`=2'b11. It takes priority over every other input.
- R12: `fallback_cause` keeps its value through later successful loads. Only a new fallback or `rst` changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_reconfig | input | 1 | External reconfigure event (pulse) |
| user_reconfig | input | 1 | User request to fetch a new start pointer (pulse) |
| wdog_timeout | input | 1 | Watchdog expiry (pulse) |
| ptr_req | output | 1 | Start-pointer read from flash in progress |
| ptr_valid | input | 1 | Flash pointer read complete |
| ptr_value | input | 32 | Start pointer returned by the flash |
| load_req | output | 1 | Image load in progress |
| load_done | input | 1 | Image load completed |
| load_err | input | 1 | Image load failed |
| image_addr | output | 32 | Start address of the image being loaded or running |
| app_mode | output | 1 | Application image selected |
| user_mode | output | 1 | An image is running in user mode |
| fallback_cause | output | 2 | Cause of the latest fallback: 00 none, 01 load error, 10 watchdog, 11 external |

## Verification
A wrong state register shows up within one clock edge: `load_req`, `ptr_req` and `user_mode` follow the state directly, so a misrouted transition produces a wrong handshake on the very next cycle. A wrong retry count is only seen when the fallback finally happens. For that reason, every error count from zero to five is swept, and the expected outcome is computed as "fallback when the count exceeds three". Address misclassification appears on `image_addr` in the cycle after `ptr_valid`, so pointers on both sides of 0 and 32, as well as the all-ones value, are checked there.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    typedef enum logic [2:0] {
        ST_LOAD_FAC = 3'd0,
        ST_FAC_USER = 3'd1,
        ST_READ_PTR = 3'd2,
        ST_LOAD_APP = 3'd3,
        ST_APP_USER = 3'd4
    } rcfg_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_LOAD_ERR = 2'b01,
        CAUSE_WDOG     = 2'b10,
        CAUSE_EXT      = 2'b11
    } rcfg_cause_e;

    typedef enum logic [1:0] {
        PTR_FACTORY  = 2'd0,
        PTR_REDIRECT = 2'd1,
        PTR_APP      = 2'd2
    } rcfg_ptr_kind_e;

    typedef struct packed {
        rcfg_state_e st;
        logic [31:0] addr;
        rcfg_cause_e cause;
    } rcfg_regs_t;

    function automatic logic is_user(input rcfg_state_e s);
        return (s == ST_FAC_USER) || (s == ST_APP_USER);
    endfunction

    function automatic logic is_app(input rcfg_state_e s);
        return (s == ST_LOAD_APP) || (s == ST_APP_USER);
    endfunction

endpackage

// File: rtl/rcfg_ptr_decode.sv
module rcfg_ptr_decode
    import rcfg_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter logic [31:0] REDIRECT_PTR  = 32'd32,
    parameter logic [31:0] REDIRECT_SLOT = 32'h0100_0000
) (
    input  logic [ADDR_W-1:0] ptr,
    output rcfg_ptr_kind_e    kind,
    output logic [ADDR_W-1:0] target
);
    localparam logic [ADDR_W-1:0] RED_P = REDIRECT_PTR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] RED_S = REDIRECT_SLOT[ADDR_W-1:0];

    always_comb begin
        if (ptr == '0) begin
            kind   = PTR_FACTORY;
            target = '0;
        end else if (ptr == RED_P) begin
            kind   = PTR_REDIRECT;
            target = RED_S;
        end else begin
            kind   = PTR_APP;
            target = ptr;
        end
    end
endmodule

// File: rtl/rcfg_retry_counter.sv
module rcfg_retry_counter #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_RETRY + 2);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (bump && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == LIMIT);
endmodule

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl
    import rcfg_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          MAX_RETRY     = 3,
    parameter logic [31:0] REDIRECT_PTR  = 32'd32,
    parameter logic [31:0] REDIRECT_SLOT = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_reconfig,
    input  logic              user_reconfig,
    input  logic              wdog_timeout,
    output logic              ptr_req,
    input  logic              ptr_valid,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic              load_req,
    input  logic              load_done,
    input  logic              load_err,
    output logic [ADDR_W-1:0] image_addr,
    output logic              app_mode,
    output logic              user_mode,
    output logic [1:0]        fallback_cause
);
    localparam logic [ADDR_W-1:0] FACTORY_ADDR = '0;

    rcfg_state_e       st_q, st_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    rcfg_cause_e       cause_q, cause_d;
    rcfg_ptr_kind_e    kind;
    logic [ADDR_W-1:0] target;
    logic              cnt_clr, cnt_bump, at_limit;

    rcfg_ptr_decode #(
        .ADDR_W(ADDR_W), .REDIRECT_PTR(REDIRECT_PTR), .REDIRECT_SLOT(REDIRECT_SLOT)
    ) dec_i (
        .ptr(ptr_value), .kind(kind), .target(target)
    );

    rcfg_retry_counter #(.MAX_RETRY(MAX_RETRY)) cnt_i (
        .clk(clk), .rst(rst), .clear(cnt_clr), .bump(cnt_bump), .at_limit(at_limit)
    );

    always_comb begin
        st_d     = st_q;
        addr_d   = addr_q;
        cause_d  = cause_q;
        cnt_clr  = 1'b0;
        cnt_bump = 1'b0;
        if (ext_reconfig) begin
            st_d    = ST_LOAD_FAC;
            addr_d  = FACTORY_ADDR;
            cause_d = CAUSE_EXT;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_LOAD_FAC: if (load_done && !load_err) st_d = ST_FAC_USER;
                ST_FAC_USER: if (user_reconfig) st_d = ST_READ_PTR;
                ST_READ_PTR: if (ptr_valid) begin
                    cnt_clr = 1'b1;
                    addr_d  = target;
                    st_d    = (kind == PTR_FACTORY) ? ST_LOAD_FAC : ST_LOAD_APP;
                end
                ST_LOAD_APP: if (load_err) begin
                    cnt_bump = 1'b1;
                    if (at_limit) begin
                        st_d    = ST_LOAD_FAC;
                        addr_d  = FACTORY_ADDR;
                        cause_d = CAUSE_LOAD_ERR;
                        cnt_clr = 1'b1;
                    end
                end else if (load_done) begin
                    st_d    = ST_APP_USER;
                    cnt_clr = 1'b1;
                end
                ST_APP_USER: if (wdog_timeout) begin
                    st_d    = ST_LOAD_FAC;
                    addr_d  = FACTORY_ADDR;
                    cause_d = CAUSE_WDOG;
                end else if (user_reconfig) begin
                    st_d = ST_READ_PTR;
                end
                default: st_d = ST_LOAD_FAC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_LOAD_FAC;
            addr_q  <= FACTORY_ADDR;
            cause_q <= CAUSE_NONE;
        end else begin
            st_q    <= st_d;
            addr_q  <= addr_d;
            cause_q <= cause_d;
        end
    end

    assign ptr_req        = (st_q == ST_READ_PTR);
    assign load_req       = (st_q == ST_LOAD_FAC) || (st_q == ST_LOAD_APP);
    assign user_mode      = is_user(st_q);
    assign app_mode       = is_app(st_q);
    assign image_addr     = addr_q;
    assign fallback_cause = cause_q;
endmodule

// File: rtl/rcfg_ctrl_chk.sv
module rcfg_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_reconfig,
    input logic              user_reconfig,
    input logic              wdog_timeout,
    input logic              ptr_req,
    input logic              ptr_valid,
    input logic [ADDR_W-1:0] ptr_value,
    input logic              load_req,
    input logic              load_done,
    input logic              load_err,
    input logic [ADDR_W-1:0] image_addr,
    input logic              app_mode,
    input logic              user_mode,
    input logic [1:0]        fallback_cause
);
    assert_ext_restart_R11: assert property (@(posedge clk) disable iff (rst)
        ext_reconfig |=> (load_req && !app_mode && image_addr == '0 && fallback_cause == 2'b11));

    assert_wdog_fallback_R9: assert property (@(posedge clk) disable iff (rst)
        (user_mode && app_mode && wdog_timeout && !ext_reconfig)
        |=> (load_req && !app_mode && fallback_cause == 2'b10));

    assert_wdog_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (user_mode && !app_mode && wdog_timeout && !ext_reconfig && !user_reconfig)
        |=> (user_mode && !app_mode && $stable(fallback_cause)));

    assert_app_enter_R6: assert property (@(posedge clk) disable iff (rst)
        (load_req && app_mode && load_done && !load_err && !ext_reconfig)
        |=> (user_mode && app_mode && $stable(image_addr)));

    assert_cause_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (fallback_cause != 2'b00) |=> (fallback_cause != 2'b00));

    assert_ptr_enter_R3: assert property (@(posedge clk) disable iff (rst)
        (user_mode && user_reconfig && !ext_reconfig && !(app_mode && wdog_timeout))
        |=> ptr_req);

    assert_handshake_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ptr_req, load_req, user_mode}));
endmodule

bind rcfg_ctrl rcfg_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .ext_reconfig(ext_reconfig), .user_reconfig(user_reconfig),
    .wdog_timeout(wdog_timeout), .ptr_req(ptr_req), .ptr_valid(ptr_valid),
    .ptr_value(ptr_value), .load_req(load_req), .load_done(load_done),
    .load_err(load_err), .image_addr(image_addr), .app_mode(app_mode),
    .user_mode(user_mode), .fallback_cause(fallback_cause)
);

// File: tb/rcfg_ctrl_tb_top.sv
module rcfg_ctrl_tb_top;
    localparam logic [31:0] SLOT = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_reconfig = 1'b0, user_reconfig = 1'b0, wdog_timeout = 1'b0;
    logic        ptr_valid = 1'b0, load_done = 1'b0, load_err = 1'b0;
    logic [31:0] ptr_value = '0;
    logic        ptr_req, load_req, app_mode, user_mode;
    logic [31:0] image_addr;
    logic [1:0]  fallback_cause;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    rcfg_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_reconfig(ext_reconfig), .user_reconfig(user_reconfig),
        .wdog_timeout(wdog_timeout), .ptr_req(ptr_req), .ptr_valid(ptr_valid),
        .ptr_value(ptr_value), .load_req(load_req), .load_done(load_done),
        .load_err(load_err), .image_addr(image_addr), .app_mode(app_mode),
        .user_mode(user_mode), .fallback_cause(fallback_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // packed view: {ptr_req, load_req, app_mode, user_mode}
    function automatic logic [31:0] flags();
        return {28'd0, ptr_req, load_req, app_mode, user_mode};
    endfunction

    task automatic boot();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic to_fac_user();
        load_done = 1'b1; step(); load_done = 1'b0;
    endtask

    task automatic give_ptr(input logic [31:0] p);
        user_reconfig = 1'b1; step(); user_reconfig = 1'b0;
        ptr_valid = 1'b1; ptr_value = p; step(); ptr_valid = 1'b0;
    endtask

    task automatic to_app_load(input logic [31:0] p);
        boot(); to_fac_user(); give_ptr(p);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] plist [6];
        plist = '{32'd1, 32'd31, 32'd33, 32'h100, 32'h00FF_0000, 32'hFFFF_FFFF};

        // R1 reset state
        @(negedge clk);
        boot();
        chk("R1 flags", flags(), 32'b0100);
        chk("R1 addr", image_addr, 32'd0);
        chk("R1 cause", {30'd0, fallback_cause}, 32'd0);

        // R2 factory load error retries, then completes
        load_err = 1'b1; step(); load_err = 1'b0;
        chk("R2 factory err keeps loading", flags(), 32'b0100);
        to_fac_user();
        chk("R2 factory user", flags(), 32'b0001);

        // R10 watchdog ignored in factory user mode
        wdog_timeout = 1'b1; step(); wdog_timeout = 1'b0;
        chk("R10 wdog in factory", flags(), 32'b0001);
        chk("R10 wdog cause", {30'd0, fallback_cause}, 32'd0);

        // R3 pointer request and pointer 0
        user_reconfig = 1'b1; step(); user_reconfig = 1'b0;
        chk("R3 ptr_req", flags(), 32'b1000);
        user_reconfig = 1'b1; step(); user_reconfig = 1'b0;
        chk("R10 reconfig during ptr read", flags(), 32'b1000);
        ptr_valid = 1'b1; ptr_value = 32'd0; step(); ptr_valid = 1'b0;
        chk("R3 ptr 0 factory load", flags(), 32'b0100);
        chk("R3 ptr 0 addr", image_addr, 32'd0);

        // R4 redirect pointer
        to_fac_user();
        give_ptr(32'd32);
        chk("R4 redirect flags", flags(), 32'b0110);
        chk("R4 redirect addr", image_addr, SLOT);

        // R5 sweep of ordinary pointers
        foreach (plist[i]) begin
            to_app_load(plist[i]);
            chk("R5 app flags", flags(), 32'b0110);
            chk("R5 app addr", image_addr, plist[i]);
        end

        // R6 error beats done, then done enters app user
        to_app_load(32'h200);
        user_reconfig = 1'b1; wdog_timeout = 1'b1; step();
        user_reconfig = 1'b0; wdog_timeout = 1'b0;
        chk("R10 inputs ignored in app load", flags(), 32'b0110);
        load_done = 1'b1; load_err = 1'b1; step(); load_done = 1'b0; load_err = 1'b0;
        chk("R6 err wins", flags(), 32'b0110);
        load_done = 1'b1; step(); load_done = 1'b0;
        chk("R6 app user", flags(), 32'b0011);
        chk("R6 addr held", image_addr, 32'h200);

        // R7 sweep of error counts 0..5
        for (int n = 0; n <= 5; n++) begin
            to_app_load(32'h4000);
            for (int k = 0; k < n; k++) begin
                load_err = 1'b1; step(); load_err = 1'b0;
            end
            if (n <= 3) begin
                chk("R7 retry flags", flags(), 32'b0110);
                chk("R7 retry addr", image_addr, 32'h4000);
                chk("R7 no cause", {30'd0, fallback_cause}, 32'd0);
                load_done = 1'b1; step(); load_done = 1'b0;
                chk("R7 success after retries", flags(), 32'b0011);
            end else begin
                chk("R7 fallback flags", flags(), 32'b0100);
                chk("R7 fallback addr", image_addr, 32'd0);
                chk("R7 fallback cause", {30'd0, fallback_cause}, 32'd1);
            end
        end

        // R8 fresh count for a new attempt after success
        to_app_load(32'h8000);
        for (int k = 0; k < 3; k++) begin
            load_err = 1'b1; step(); load_err = 1'b0;
        end
        load_done = 1'b1; step(); load_done = 1'b0;
        give_ptr(32'h9000);
        chk("R8 app-to-app load", image_addr, 32'h9000);
        for (int k = 0; k < 3; k++) begin
            load_err = 1'b1; step(); load_err = 1'b0;
        end
        chk("R8 count restarted", flags(), 32'b0110);
        load_err = 1'b1; step(); load_err = 1'b0;
        chk("R8 fourth error falls back", flags(), 32'b0100);

        // R9 watchdog in app user
        to_app_load(32'h300);
        load_done = 1'b1; step(); load_done = 1'b0;
        wdog_timeout = 1'b1; step(); wdog_timeout = 1'b0;
        chk("R9 wdog flags", flags(), 32'b0100);
        chk("R9 wdog cause", {30'd0, fallback_cause}, 32'd2);

        // R12 cause persists through successful runs
        to_fac_user();
        give_ptr(32'h500);
        load_done = 1'b1; step(); load_done = 1'b0;
        chk("R12 cause kept", {30'd0, fallback_cause}, 32'd2);

        // R11 external reconfigure beats watchdog and done
        ext_reconfig = 1'b1; wdog_timeout = 1'b1; step();
        ext_reconfig = 1'b0; wdog_timeout = 1'b0;
        chk("R11 ext flags", flags(), 32'b0100);
        chk("R11 ext cause", {30'd0, fallback_cause}, 32'd3);
        chk("R11 ext addr", image_addr, 32'd0);
        give_ptr(32'h0);
        ext_reconfig = 1'b1; load_done = 1'b1; step();
        ext_reconfig = 1'b0; load_done = 1'b0;
        chk("R11 ext over done", flags(), 32'b0100);

        // R12 / R1 reset clears cause
        boot();
        chk("R12 reset clears cause", {30'd0, fallback_cause}, 32'd0);

        finish_run();
    end
endmodule